// File: doc/BRIEF.md
# Masked Address Watchpoint Unit

This block observes the addresses that a transfer engine presents to main memory and reports any access that lands on a programmed address, or inside a programmed address range. A watch address and a mask are held in a small register file. A mask bit set to 1 takes the matching address bit out of the comparison. An all-zero mask therefore matches exactly one address, and a mask with its low bits set matches an aligned block.

A hit sets a sticky status flag. When the break-enable bit is also set, the hit raises a level halt request toward the processor. Software programs the watch address and mask over a simple register bus, and those writes only take effect while the system is held in debug mode.

The configuration and the status flag belong to the test-reset domain, so a functional reset of the chip does not disturb a debug session. Only the internal hit pipeline stage is cleared by the functional reset.

Top module: `addr_watch_unit`

## Requirements
- R1: While `trstN` is low, the watch address, the mask, the break enable and the status flag are all cleared. Reads of offsets 0x58, 0x5C and 0x50 then return zero, and `hitFlag` and `haltReq` are low.
- R2: A pulse on `rstFuncN` leaves the watch address, the mask, the break enable and the status flag unchanged. It does discard a hit that is still in the pipeline stage.
- R3: A write to offset 0x58 (watch address) or 0x5C (mask) updates the register only when `dbgMode` is 1 at the write edge. With `dbgMode` at 0 the write is ignored.
- R4: `regRdata` returns the stored watch address at 0x58, the stored mask at 0x5C, and the control word at 0x50. The control word carries the status flag in bit 8 and the break enable in bit 0. Any other offset reads zero.
- R5: A cycle with `memValid` high and `((memAddr ^ watch) & ~mask) == 0` is a hit. `hitFlag` rises after the second rising edge following that cycle.
- R6: Cycles with `memValid` low never produce a hit, whatever `memAddr` holds.
- R7: The status flag is sticky. Only a write to 0x50 with bit 8 set, or the test reset, clears it. A write with bit 8 at 0 leaves it set.
- R8: When a hit reaches the status stage in the same cycle as a clear write, the flag stays set.
- R9: `haltReq` is high exactly when the status flag and the break enable are both set. It follows either of them going low at the same edge.
- R10: Bit 0 of a write to 0x50 sets the break enable in any mode, independent of `dbgMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstFuncN | input | 1 | Functional reset, active low, asynchronous; clears only the hit pipeline stage |
| trstN | input | 1 | Test reset, active low, asynchronous; clears configuration and status |
| dbgMode | input | 1 | High while the system is in debug/suspend mode |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset |
| regWdata | input | ADDR_W | Register write data |
| regRdata | output | ADDR_W | Register read data (combinational on regAddr) |
| memValid | input | 1 | Qualifies memAddr as a live access |
| memAddr | input | ADDR_W | Main memory address issued by the transfer engine |
| hitFlag | output | 1 | Sticky watchpoint status |
| haltReq | output | 1 | Halt request toward the processor |

## Verification
A corrupted watch address or mask can only be seen in two ways: through readback, or through the pattern of hits. The bench therefore compares both every cycle against a model. A wrong comparison shows on `hitFlag` exactly two edges after the offending access, and a lost or spurious clear shows one edge after the clear write. Random addresses are biased to land inside and just outside the masked window, so that a single wrong mask bit produces a flag mismatch within a few cycles.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h50;
  localparam logic [7:0] OFF_POINT = 8'h58;
  localparam logic [7:0] OFF_MASK  = 8'h5C;
  localparam int unsigned STAT_BIT = 8;
  localparam int unsigned BRK_BIT  = 0;

  typedef struct packed {
    logic wrPoint;
    logic wrMask;
    logic wrCtrl;
    logic clrStatus;
    logic selPoint;
    logic selMask;
    logic selCtrl;
  } awuStrobes_t;
endpackage

// File: rtl/awu_ctrl.sv
module awu_ctrl
  import awu_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              dbgMode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output awuStrobes_t       strobes
);
  localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(OFF_CTRL);
  localparam logic [REG_AW-1:0] A_POINT = REG_AW'(OFF_POINT);
  localparam logic [REG_AW-1:0] A_MASK  = REG_AW'(OFF_MASK);

  logic hitCtrl, hitPoint, hitMask;

  always_comb begin
    hitCtrl  = (regAddr == A_CTRL);
    hitPoint = (regAddr == A_POINT);
    hitMask  = (regAddr == A_MASK);

    strobes.selCtrl   = hitCtrl;
    strobes.selPoint  = hitPoint;
    strobes.selMask   = hitMask;
    // configuration writes land only in debug mode
    strobes.wrPoint   = regWrEn & hitPoint & dbgMode;
    strobes.wrMask    = regWrEn & hitMask & dbgMode;
    strobes.wrCtrl    = regWrEn & hitCtrl;
    strobes.clrStatus = regWrEn & hitCtrl & regWdata[STAT_BIT];
  end
endmodule

// File: rtl/awu_datapath.sv
module awu_datapath
  import awu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstFuncN,
  input  logic              trstN,
  input  awuStrobes_t       strobes,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              statusQ,
  output logic              breakEnQ
);
  logic [ADDR_W-1:0] watchPoint;
  logic [ADDR_W-1:0] watchMask;
  logic [ADDR_W-1:0] bitOk;
  logic              addrMatch;
  logic              hitQ;

  // configuration: test-reset domain
  always_ff @(posedge clk or negedge trstN) begin
    if (!trstN) begin
      watchPoint <= '0;
      watchMask  <= '0;
      breakEnQ   <= 1'b0;
    end else begin
      if (strobes.wrPoint) watchPoint <= regWdata;
      if (strobes.wrMask)  watchMask  <= regWdata;
      if (strobes.wrCtrl)  breakEnQ   <= regWdata[BRK_BIT];
    end
  end

  // per-bit masked comparison
  for (genvar b = 0; b < ADDR_W; b++) begin : g_cmp
    assign bitOk[b] = watchMask[b] | ~(memAddr[b] ^ watchPoint[b]);
  end
  assign addrMatch = &bitOk;

  // hit pipeline stage: functional-reset domain
  always_ff @(posedge clk or negedge rstFuncN) begin
    if (!rstFuncN) hitQ <= 1'b0;
    else           hitQ <= memValid & addrMatch;
  end

  // sticky status: test-reset domain, hit beats clear
  always_ff @(posedge clk or negedge trstN) begin
    if (!trstN)            statusQ <= 1'b0;
    else if (hitQ)         statusQ <= 1'b1;
    else if (strobes.clrStatus) statusQ <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    if (strobes.selPoint) regRdata = watchPoint;
    else if (strobes.selMask) regRdata = watchMask;
    else if (strobes.selCtrl) begin
      regRdata[STAT_BIT] = statusQ;
      regRdata[BRK_BIT]  = breakEnQ;
    end
  end
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstFuncN,
  input  logic              trstN,
  input  logic              dbgMode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              hitFlag,
  output logic              haltReq
);
  awuStrobes_t strobes;
  logic        statusQ;
  logic        breakEnQ;

  awu_ctrl #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) ctrl_i (
    .dbgMode (dbgMode),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strobes (strobes)
  );

  awu_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstFuncN(rstFuncN),
    .trstN   (trstN),
    .strobes (strobes),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .memValid(memValid),
    .memAddr (memAddr),
    .statusQ (statusQ),
    .breakEnQ(breakEnQ)
  );

  assign hitFlag = statusQ;
  assign haltReq = statusQ & breakEnQ;
endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 8
) (
  input logic              clk,
  input logic              rstFuncN,
  input logic              trstN,
  input logic              dbgMode,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [ADDR_W-1:0] regWdata,
  input logic              memValid,
  input logic              hitFlag,
  input logic              haltReq,
  input logic [ADDR_W-1:0] pointQ,
  input logic [ADDR_W-1:0] maskQ
);
  logic clrWrite;
  assign clrWrite = regWrEn && (regAddr == REG_AW'(8'h50)) && regWdata[8];

  // R3
  point_locked_chk: assert property (@(posedge clk) disable iff (!trstN || !rstFuncN)
    !dbgMode |=> $stable(pointQ));
  // R3
  mask_locked_chk: assert property (@(posedge clk) disable iff (!trstN || !rstFuncN)
    !dbgMode |=> $stable(maskQ));
  // R7
  sticky_status_chk: assert property (@(posedge clk) disable iff (!trstN || !rstFuncN)
    hitFlag && !clrWrite |=> hitFlag);
  // R5
  hit_latency_chk: assert property (@(posedge clk) disable iff (!trstN || !rstFuncN)
    $rose(hitFlag) |-> $past(memValid, 2));
  // R9
  halt_needs_flag_chk: assert property (@(posedge clk) disable iff (!trstN)
    haltReq |-> hitFlag);
endmodule

bind addr_watch_unit awu_checker #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) chk_i (
  .clk     (clk),
  .rstFuncN(rstFuncN),
  .trstN   (trstN),
  .dbgMode (dbgMode),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .memValid(memValid),
  .hitFlag (hitFlag),
  .haltReq (haltReq),
  .pointQ  (dp_i.watchPoint),
  .maskQ   (dp_i.watchMask)
);

// File: tb/addr_watch_unit_tb.sv
module addr_watch_unit_tb_top;
  localparam int ADDR_W = 32;
  localparam int REG_AW = 8;

  logic              clk = 1'b0;
  logic              rstFuncN = 1'b0;
  logic              trstN = 1'b0;
  logic              dbgMode = 1'b0;
  logic              regWrEn = 1'b0;
  logic [REG_AW-1:0] regAddr = '0;
  logic [ADDR_W-1:0] regWdata = '0;
  logic [ADDR_W-1:0] regRdata;
  logic              memValid = 1'b0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic              hitFlag;
  logic              haltReq;

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] mPoint = '0, mMask = '0;
  logic        mBrk = 1'b0, mStatus = 1'b0, mHitQ = 1'b0;

  always #4 clk = ~clk;

  addr_watch_unit #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) dut_i (
    .clk(clk), .rstFuncN(rstFuncN), .trstN(trstN), .dbgMode(dbgMode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memValid(memValid), .memAddr(memAddr), .hitFlag(hitFlag), .haltReq(haltReq)
  );

  function automatic logic expHit(logic v, logic [31:0] a, logic [31:0] p, logic [31:0] m);
    return v && (((a ^ p) & ~m) == 32'h0);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic cyc(logic v, logic [31:0] a, logic wr, logic [7:0] wa, logic [31:0] wd, string tag);
    logic newHit, clr;
    memValid = v; memAddr = a; regWrEn = wr; regAddr = wa; regWdata = wd;
    newHit = expHit(v, a, mPoint, mMask);
    clr = 1'b0;
    @(posedge clk);
    if (wr) begin
      if (wa == 8'h58 && dbgMode) mPoint = wd;
      if (wa == 8'h5C && dbgMode) mMask = wd;
      if (wa == 8'h50) begin mBrk = wd[0]; clr = wd[8]; end
    end
    mStatus = mHitQ ? 1'b1 : (clr ? 1'b0 : mStatus);
    mHitQ = newHit;
    @(negedge clk);
    regWrEn = 1'b0; memValid = 1'b0;
    chk({tag, " hitFlag"}, {31'h0, hitFlag}, {31'h0, mStatus});
    chk({tag, " R9 haltReq"}, {31'h0, haltReq}, {31'h0, mStatus & mBrk});
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    regAddr = a; #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, $urandom, 1'b0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(8'h58, 32'h0, "R1 point reset");
    rd(8'h5C, 32'h0, "R1 mask reset");
    rd(8'h50, 32'h0, "R1 ctrl reset");
    chk("R1 hitFlag reset", {31'h0, hitFlag}, 32'h0);
    chk("R1 haltReq reset", {31'h0, haltReq}, 32'h0);
    trstN = 1'b1; rstFuncN = 1'b1;
    @(negedge clk);

    // R3 writes ignored outside debug mode
    cyc(1'b0, 0, 1'b1, 8'h58, 32'hDEAD_BEEF, "R3 locked point");
    cyc(1'b0, 0, 1'b1, 8'h5C, 32'h0000_00FF, "R3 locked mask");
    rd(8'h58, 32'h0, "R3 point unchanged");
    rd(8'h5C, 32'h0, "R3 mask unchanged");
    // R3/R4 writes in debug mode and readback
    dbgMode = 1'b1;
    cyc(1'b0, 0, 1'b1, 8'h58, 32'h8000_1234, "R3 write point");
    cyc(1'b0, 0, 1'b1, 8'h5C, 32'h0, "R3 write mask");
    rd(8'h58, 32'h8000_1234, "R4 point readback");
    rd(8'h5C, 32'h0, "R4 mask readback");
    rd(8'h44, 32'h0, "R4 unmapped zero");
    rd(8'hFC, 32'h0, "R4 unmapped zero high");
    dbgMode = 1'b0;

    // R6 invalid cycle with matching address
    cyc(1'b0, 32'h8000_1234, 1'b0, 0, 0, "R6 invalid match");
    idle(2, "R6 idle");
    chk("R6 no hit", {31'h0, hitFlag}, 32'h0);
    // R5 exact hit, latency
    cyc(1'b1, 32'h8000_1235, 1'b0, 0, 0, "R5 near miss");
    cyc(1'b1, 32'h8000_1234, 1'b0, 0, 0, "R5 exact hit c1");
    chk("R5 not yet after one edge", {31'h0, hitFlag}, 32'h0);
    idle(1, "R5 exact hit c2");
    chk("R5 flag after two edges", {31'h0, hitFlag}, 32'h1);
    // R10 break enable in non-debug mode, R9 halt
    cyc(1'b0, 0, 1'b1, 8'h50, 32'h0000_0001, "R10 set break");
    chk("R9 halt level", {31'h0, haltReq}, 32'h1);
    rd(8'h50, 32'h0000_0101, "R4 ctrl readback");
    // R7 write without bit 8 keeps flag
    cyc(1'b0, 0, 1'b1, 8'h50, 32'h0000_0001, "R7 no clear");
    chk("R7 still set", {31'h0, hitFlag}, 32'h1);
    // R9 break disable drops halt
    cyc(1'b0, 0, 1'b1, 8'h50, 32'h0000_0000, "R9 break off");
    chk("R9 halt dropped", {31'h0, haltReq}, 32'h0);
    cyc(1'b0, 0, 1'b1, 8'h50, 32'h0000_0101, "R7 clear");
    chk("R7 cleared", {31'h0, hitFlag}, 32'h0);

    // R8 hit vs clear in same cycle
    cyc(1'b1, 32'h8000_1234, 1'b0, 0, 0, "R8 hit");
    cyc(1'b0, 0, 1'b1, 8'h50, 32'h0000_0101, "R8 clear with hit");
    chk("R8 hit wins", {31'h0, hitFlag}, 32'h1);

    // R2 functional reset keeps config/status, drops pending hit
    cyc(1'b0, 0, 1'b1, 8'h50, 32'h0000_0101, "R2 clear");
    memValid = 1'b1; memAddr = 32'h8000_1234;
    @(posedge clk);
    mHitQ = 1'b1;
    #1 rstFuncN = 1'b0; memValid = 1'b0;
    mHitQ = 1'b0;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rstFuncN = 1'b1;
    idle(2, "R2 after func reset");
    chk("R2 pending hit dropped", {31'h0, hitFlag}, 32'h0);
    rd(8'h58, 32'h8000_1234, "R2 point kept");
    rd(8'h50, 32'h0000_0001, "R2 break kept");

    // R5 masked range, random with bias
    dbgMode = 1'b1;
    cyc(1'b0, 0, 1'b1, 8'h58, 32'h4000_0000, "R3 point");
    cyc(1'b0, 0, 1'b1, 8'h5C, 32'h0000_0FFF, "R3 mask");
    dbgMode = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [2:0]  sel;
      sel = 3'($urandom);
      if (sel < 3) a = mPoint ^ ($urandom & mMask);
      else if (sel < 5) a = mPoint ^ (32'h1 << ($urandom % 32));
      else a = $urandom;
      if (i % 37 == 0) begin
        dbgMode = $urandom % 2;
        cyc(1'b0, 0, 1'b1, ($urandom % 2) ? 8'h58 : 8'h5C,
            32'h4000_0000 | ($urandom & 32'h0000_FFFF), "R3 random cfg write");
      end else if (i % 11 == 0)
        cyc(1'($urandom), a, 1'b1, 8'h50, $urandom & 32'h0000_0101, "R7 random clear");
      else
        cyc(1'($urandom), a, 1'b0, 0, 0, "R5 random access");
    end
    rd(8'h58, mPoint, "R4 final point");
    rd(8'h5C, mMask, "R4 final mask");

    // R1 test reset clears all
    trstN = 1'b0; #1;
    mPoint = 0; mMask = 0; mBrk = 0; mStatus = 0; mHitQ = 0;
    rd(8'h58, 32'h0, "R1 point cleared");
    rd(8'h50, 32'h0, "R1 ctrl cleared");
    chk("R1 flag cleared", {31'h0, hitFlag}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule